// File: doc/BRIEF.md
# Per-pixel write gate (alpha, destination-alpha and depth tests)

This block sits at the end of a pixel pipeline and decides, for every pixel presented with a valid strobe, which parts of the frame buffer and depth buffer may be written. It takes three 64-bit control words: a test-control word, a depth-buffer control word and a frame control word. It also takes the pixel's alpha and depth, the depth already stored at that location, and the stored color. It produces a write enable for the RGB channels, a write enable for the alpha channel, a per-bit color write enable and a depth write enable. All outputs are registered one clock after the pixel arrives, together with an output valid.

A pixel that fails the alpha comparison is not always discarded. A 2-bit fail policy can still let it write the whole frame, only the depth, or only the RGB channels. A failed depth comparison suppresses every write. A failed destination-alpha check also suppresses every write. The stored-depth mask bit blocks depth writes, and the frame write mask removes individual color bits.

Top module: `pix_write_gate`

## Requirements
- R1: The test-control word fields are alpha-test enable at bit 0, alpha compare code at bits 3:1, reference alpha at bits 11:4, fail policy at bits 13:12, destination-alpha enable at bit 14, destination-alpha mode at bit 15, depth-test enable at bit 16 and depth compare code at bits 18:17. Alpha compare codes compare the pixel alpha with the reference: 0 never, 1 always, 2 less, 3 less-or-equal, 4 equal, 5 greater-or-equal, 6 greater, 7 not-equal. A pixel that passes writes RGB, alpha and depth, subject to R4 to R8.
- R2: With the alpha-test enable clear, every pixel counts as passing the alpha test, whatever the compare code.
- R3: A pixel that fails the alpha test follows the fail policy. Policy 0 writes nothing. Policy 1 writes RGB and alpha but not depth. Policy 2 writes depth only. Policy 3 writes RGB only.
- R4: Depth compare codes compare the incoming depth, treated as unsigned, with the stored depth: 0 never, 1 always, 2 greater-or-equal, 3 greater. With the depth-test enable clear, the depth test passes.
- R5: A pixel that fails the depth test writes nothing, whatever its alpha result.
- R6: With destination-alpha enabled, a pixel whose stored color bit 31 differs from the mode bit writes nothing.
- R7: When bit 32 of the depth-buffer control word is set, the depth write enable is never raised.
- R8: Bits 63:32 of the frame control word are a write mask: a set bit forces the matching bit of out_bit_en low. Color bits 23:0 belong to RGB and bits 31:24 to alpha. out_rgb_en is set when any of bits 23:0 of out_bit_en is set, and out_a_en when any of bits 31:24 is set.
- R9: Outputs appear one clock after the input, and out_valid repeats in_valid with that delay. While out_valid is low, and after reset, every enable is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| test_ctl | input | 64 | Test-control word (fields in R1) |
| zbuf_ctl | input | 64 | Depth-buffer control word, bit 32 masks depth writes |
| frame_ctl | input | 64 | Frame control word, bits 63:32 are the color write mask |
| px_alpha | input | 8 | Incoming pixel alpha |
| px_depth | input | DEPTH_W | Incoming pixel depth |
| dst_depth | input | DEPTH_W | Depth stored at the pixel location |
| dst_color | input | 32 | Color stored at the pixel location |
| out_valid | output | 1 | Registered result valid |
| out_rgb_en | output | 1 | Some RGB bit is written |
| out_a_en | output | 1 | Some alpha bit is written |
| out_z_en | output | 1 | Depth is written |
| out_bit_en | output | 32 | Per-bit color write enable |

## Verification
Every result of this block is due on the first rising edge after the pixel is presented, because exactly one register stage lies between the inputs and the outputs. The bench therefore changes the inputs on a falling edge and compares all five outputs on the next falling edge, half a period after that single register has loaded. With in_valid low, it checks on the same schedule that all enables are zero. Reset values are sampled while reset is still held.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    localparam int COLOR_W     = 32;
    localparam int ALPHA_W     = 8;
    localparam int RGB_BITS    = 24;
    localparam int TC_ATE      = 0;
    localparam int TC_ATST_LO  = 1;
    localparam int TC_AREF_LO  = 4;
    localparam int TC_AFAIL_LO = 12;
    localparam int TC_DATE     = 14;
    localparam int TC_DATM     = 15;
    localparam int TC_ZTE      = 16;
    localparam int TC_ZTST_LO  = 17;
    localparam int ZB_ZMSK     = 32;
    localparam int FB_MSK_LO   = 32;

    typedef enum logic [2:0] {
        ACMP_NEVER, ACMP_ALWAYS, ACMP_LT, ACMP_LE,
        ACMP_EQ, ACMP_GE, ACMP_GT, ACMP_NE
    } acmp_e;

    typedef enum logic [1:0] {
        ZCMP_NEVER, ZCMP_ALWAYS, ZCMP_GE, ZCMP_GT
    } zcmp_e;

    typedef enum logic [1:0] {
        FAIL_NONE, FAIL_FRAME, FAIL_DEPTH, FAIL_RGB
    } afail_e;

    typedef struct packed {
        logic               ate;
        acmp_e              atst;
        logic [ALPHA_W-1:0] aref;
        afail_e             afail;
        logic               date;
        logic               datm;
        logic               zte;
        zcmp_e              ztst;
    } test_fields_t;

    typedef struct packed {
        logic               vld;
        logic               rgb;
        logic               a;
        logic               z;
        logic [COLOR_W-1:0] bits;
    } gate_out_t;

    function automatic test_fields_t split_test(input logic [63:0] w);
        test_fields_t f;
        f.ate   = w[TC_ATE];
        f.atst  = acmp_e'(w[TC_ATST_LO +: 3]);
        f.aref  = w[TC_AREF_LO +: ALPHA_W];
        f.afail = afail_e'(w[TC_AFAIL_LO +: 2]);
        f.date  = w[TC_DATE];
        f.datm  = w[TC_DATM];
        f.zte   = w[TC_ZTE];
        f.ztst  = zcmp_e'(w[TC_ZTST_LO +: 2]);
        return f;
    endfunction
endpackage

// File: rtl/pwg_alpha_cmp.sv
module pwg_alpha_cmp
    import pwg_pkg::*;
(
    input  acmp_e              mode,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic [ALPHA_W-1:0] aref,
    output logic               pass
);
    always_comb begin
        unique case (mode)
            ACMP_NEVER:  pass = 1'b0;
            ACMP_ALWAYS: pass = 1'b1;
            ACMP_LT:     pass = alpha <  aref;
            ACMP_LE:     pass = alpha <= aref;
            ACMP_EQ:     pass = alpha == aref;
            ACMP_GE:     pass = alpha >= aref;
            ACMP_GT:     pass = alpha >  aref;
            default:     pass = alpha != aref;
        endcase
    end
endmodule

// File: rtl/pwg_depth_cmp.sv
module pwg_depth_cmp
    import pwg_pkg::*;
#(
    parameter int W = 32
) (
    input  zcmp_e        mode,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic         pass
);
    always_comb begin
        unique case (mode)
            ZCMP_NEVER:  pass = 1'b0;
            ZCMP_ALWAYS: pass = 1'b1;
            ZCMP_GE:     pass = src >= dst;
            default:     pass = src >  dst;
        endcase
    end
endmodule

// File: rtl/pwg_decide.sv
module pwg_decide
    import pwg_pkg::*;
(
    input  logic   alpha_ok,
    input  logic   depth_ok,
    input  logic   dest_ok,
    input  afail_e policy,
    output logic   want_rgb,
    output logic   want_a,
    output logic   want_z
);
    always_comb begin
        want_rgb = 1'b0;
        want_a   = 1'b0;
        want_z   = 1'b0;
        if (depth_ok && dest_ok) begin
            if (alpha_ok) begin
                want_rgb = 1'b1;
                want_a   = 1'b1;
                want_z   = 1'b1;
            end else begin
                unique case (policy)
                    FAIL_FRAME: begin
                        want_rgb = 1'b1;
                        want_a   = 1'b1;
                    end
                    FAIL_DEPTH: want_z   = 1'b1;
                    FAIL_RGB:   want_rgb = 1'b1;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pix_write_gate.sv
module pix_write_gate
    import pwg_pkg::*;
#(
    parameter int DEPTH_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [63:0]        test_ctl,
    input  logic [63:0]        zbuf_ctl,
    input  logic [63:0]        frame_ctl,
    input  logic [ALPHA_W-1:0] px_alpha,
    input  logic [DEPTH_W-1:0] px_depth,
    input  logic [DEPTH_W-1:0] dst_depth,
    input  logic [COLOR_W-1:0] dst_color,
    output logic               out_valid,
    output logic               out_rgb_en,
    output logic               out_a_en,
    output logic               out_z_en,
    output logic [COLOR_W-1:0] out_bit_en
);
    localparam int A_BITS = COLOR_W - RGB_BITS;

    test_fields_t       tf;
    logic               acmp_pass;
    logic               zcmp_pass;
    logic               alpha_ok;
    logic               depth_ok;
    logic               dest_ok;
    logic               want_rgb;
    logic               want_a;
    logic               want_z;
    logic [COLOR_W-1:0] fb_mask;
    gate_out_t          res_d;
    gate_out_t          res_q;
    logic               unused_ctl_bits;

    assign tf      = split_test(test_ctl);
    assign fb_mask = frame_ctl[FB_MSK_LO +: COLOR_W];
    assign unused_ctl_bits = ^{test_ctl[63:19], zbuf_ctl[63:33],
                               zbuf_ctl[31:0], frame_ctl[31:0],
                               dst_color[COLOR_W-2:0]};

    pwg_alpha_cmp u_acmp (
        .mode  (tf.atst),
        .alpha (px_alpha),
        .aref  (tf.aref),
        .pass  (acmp_pass)
    );

    pwg_depth_cmp #(.W(DEPTH_W)) u_zcmp (
        .mode (tf.ztst),
        .src  (px_depth),
        .dst  (dst_depth),
        .pass (zcmp_pass)
    );

    assign alpha_ok = !tf.ate || acmp_pass;
    assign depth_ok = !tf.zte || zcmp_pass;
    assign dest_ok  = !tf.date || (dst_color[COLOR_W-1] == tf.datm);

    pwg_decide u_decide (
        .alpha_ok (alpha_ok),
        .depth_ok (depth_ok),
        .dest_ok  (dest_ok),
        .policy   (tf.afail),
        .want_rgb (want_rgb),
        .want_a   (want_a),
        .want_z   (want_z)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.bits = {{A_BITS{want_a}}, {RGB_BITS{want_rgb}}} & ~fb_mask;
            res_d.rgb  = |res_d.bits[RGB_BITS-1:0];
            res_d.a    = |res_d.bits[COLOR_W-1:RGB_BITS];
            res_d.z    = want_z && !zbuf_ctl[ZB_ZMSK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.vld;
    assign out_rgb_en = res_q.rgb;
    assign out_a_en   = res_q.a;
    assign out_z_en   = res_q.z;
    assign out_bit_en = res_q.bits;
endmodule

// File: rtl/pix_write_gate_chk.sv
module pix_write_gate_chk #(
    parameter int DEPTH_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [63:0]        test_ctl,
    input logic [63:0]        zbuf_ctl,
    input logic [63:0]        frame_ctl,
    input logic [7:0]         px_alpha,
    input logic [DEPTH_W-1:0] px_depth,
    input logic [DEPTH_W-1:0] dst_depth,
    input logic [31:0]        dst_color,
    input logic               out_valid,
    input logic               out_rgb_en,
    input logic               out_a_en,
    input logic               out_z_en,
    input logic [31:0]        out_bit_en
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_rgb_en && !out_a_en && !out_z_en && out_bit_en == 32'd0));

    p_keep_policy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && test_ctl[0] && test_ctl[3:1] == 3'd0 && test_ctl[13:12] == 2'd0)
        |-> (!out_rgb_en && !out_a_en && !out_z_en));

    p_depth_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && test_ctl[16] && test_ctl[18:17] == 2'd0)
        |-> (!out_rgb_en && !out_a_en && !out_z_en && out_bit_en == 32'd0));

    p_dest_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && test_ctl[14] && (dst_color[31] != test_ctl[15]))
        |-> (!out_rgb_en && !out_a_en && !out_z_en));

    p_zmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && zbuf_ctl[32]) |-> !out_z_en);

    p_fbmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_bit_en & $past(frame_ctl[63:32])) == 32'd0));
endmodule

bind pix_write_gate pix_write_gate_chk #(.DEPTH_W(DEPTH_W)) u_chk (.*);

// File: tb/tb_pix_write_gate.sv
`timescale 1ns/1ps
module tb_pix_write_gate;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   test_ctl = '0;
    logic [63:0]   zbuf_ctl = '0;
    logic [63:0]   frame_ctl = '0;
    logic [7:0]    px_alpha = '0;
    logic [DW-1:0] px_depth = '0;
    logic [DW-1:0] dst_depth = '0;
    logic [31:0]   dst_color = '0;
    logic          out_valid, out_rgb_en, out_a_en, out_z_en;
    logic [31:0]   out_bit_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pix_write_gate #(.DEPTH_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .test_ctl(test_ctl), .zbuf_ctl(zbuf_ctl), .frame_ctl(frame_ctl),
        .px_alpha(px_alpha), .px_depth(px_depth), .dst_depth(dst_depth),
        .dst_color(dst_color), .out_valid(out_valid), .out_rgb_en(out_rgb_en),
        .out_a_en(out_a_en), .out_z_en(out_z_en), .out_bit_en(out_bit_en)
    );

    function automatic logic [63:0] mk_test(bit ate, int atst, int aref, int afail,
                                            bit date, bit datm, bit zte, int ztst);
        logic [63:0] w = '0;
        w[0]     = ate;
        w[3:1]   = 3'(atst);
        w[11:4]  = 8'(aref);
        w[13:12] = 2'(afail);
        w[14]    = date;
        w[15]    = datm;
        w[16]    = zte;
        w[18:17] = 2'(ztst);
        return w;
    endfunction

    // expected {valid, rgb, a, z, bits}
    function automatic logic [35:0] model(bit v, logic [63:0] t, logic [63:0] zb,
                                          logic [63:0] fb, logic [7:0] al,
                                          logic [DW-1:0] z, logic [DW-1:0] sz,
                                          logic [31:0] dc);
        bit apass, zpass, dok, wr, wa, wz;
        logic [31:0] bits;
        int ar = int'(t[11:4]);
        int a = int'(al);
        if (!v) return 36'd0;
        case (int'(t[3:1]))
            0: apass = 0;
            1: apass = 1;
            2: apass = a < ar;
            3: apass = a <= ar;
            4: apass = a == ar;
            5: apass = a >= ar;
            6: apass = a > ar;
            default: apass = a != ar;
        endcase
        if (!t[0]) apass = 1;
        case (int'(t[18:17]))
            0: zpass = 0;
            1: zpass = 1;
            2: zpass = z >= sz;
            default: zpass = z > sz;
        endcase
        if (!t[16]) zpass = 1;
        dok = !t[14] || (dc[31] == t[15]);
        wr = 0; wa = 0; wz = 0;
        if (zpass && dok) begin
            if (apass) begin wr = 1; wa = 1; wz = 1; end
            else case (int'(t[13:12]))
                1: begin wr = 1; wa = 1; end
                2: wz = 1;
                3: wr = 1;
                default: ;
            endcase
        end
        if (zb[32]) wz = 0;
        bits = 32'h0;
        if (wr) bits[23:0] = ~fb[55:32];
        if (wa) bits[31:24] = ~fb[63:56];
        return {1'b1, |bits[23:0], |bits[31:24], wz, bits};
    endfunction

    task automatic compare(string tag, logic [35:0] exp);
        logic [35:0] got = {out_valid, out_rgb_en, out_a_en, out_z_en, out_bit_en};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (test=%h zb=%h fb=%h a=%h z=%h sz=%h)",
                     tag, got, exp, test_ctl, zbuf_ctl, frame_ctl, px_alpha, px_depth,
                     dst_depth);
        end
    endtask

    task automatic run(string tag, bit v, logic [63:0] t, logic [63:0] zb, logic [63:0] fb,
                       logic [7:0] al, logic [DW-1:0] z, logic [DW-1:0] sz, logic [31:0] dc);
        @(negedge clk);
        in_valid = v; test_ctl = t; zbuf_ctl = zb; frame_ctl = fb;
        px_alpha = al; px_depth = z; dst_depth = sz; dst_color = dc;
        @(negedge clk);
        compare(tag, model(v, t, zb, fb, al, z, sz, dc));
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] avals [5] = '{8'h00, 8'h7F, 8'h80, 8'h81, 8'hFF};
        logic [DW-1:0] zvals [3] = '{32'd999, 32'd1000, 32'd1001};
        logic [31:0] masks [6] = '{32'h0, 32'hFFFFFFFF, 32'h00FFFFFF, 32'hFF000000,
                                   32'hA5A5A5A5, 32'h00000001};
        repeat (3) @(negedge clk);
        compare("R9 reset", 36'd0);
        rst_n = 1'b1;

        // R9: idle input with all-pass controls produces no enables
        run("R9 idle", 0, mk_test(0, 1, 0, 0, 0, 0, 0, 1), 64'h0, 64'h0, 8'h80, 32'd5, 32'd1, 32'h0);

        // R1 R2 R3 R4 R5: sweep of compare codes, policies and operand orderings
        for (int ate = 0; ate < 2; ate++)
            for (int at = 0; at < 8; at++)
                for (int af = 0; af < 4; af++)
                    for (int ai = 0; ai < 5; ai++)
                        for (int zt = 0; zt < 4; zt++)
                            for (int zi = 0; zi < 3; zi++)
                                run("R1/R2/R3/R4/R5 sweep", 1,
                                    mk_test(bit'(ate), at, 8'h80, af, 0, 0, 1, zt),
                                    64'h0, 64'h0, avals[ai], zvals[zi], 32'd1000, 32'h0);

        // R1: reference at the range ends
        for (int at = 0; at < 8; at++)
            for (int r = 0; r < 2; r++)
                for (int a = 0; a < 2; a++)
                    run("R1 alpha edges", 1, mk_test(1, at, r * 255, 0, 0, 0, 0, 0),
                        64'h0, 64'h0, 8'(a * 255), 32'd0, 32'd0, 32'h0);

        // R4: depth test disabled and extreme depth values
        for (int zt = 0; zt < 4; zt++) begin
            run("R4 depth off", 1, mk_test(0, 0, 0, 0, 0, 0, 0, zt), 64'h0, 64'h0,
                8'h0, 32'd0, 32'hFFFFFFFF, 32'h0);
            run("R4 depth max", 1, mk_test(0, 0, 0, 0, 0, 0, 1, zt), 64'h0, 64'h0,
                8'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0);
            run("R4 depth zero", 1, mk_test(0, 0, 0, 0, 0, 0, 1, zt), 64'h0, 64'h0,
                8'h0, 32'h0, 32'hFFFFFFFE, 32'h0);
        end

        // R6: destination-alpha test
        for (int de = 0; de < 2; de++)
            for (int dm = 0; dm < 2; dm++)
                for (int b = 0; b < 2; b++)
                    for (int af = 0; af < 4; af++)
                        run("R6 dest alpha", 1, mk_test(1, 0, 0, af, bit'(de), bit'(dm), 0, 0),
                            64'h0, 64'h0, 8'h10, 32'd0, 32'd0, {b[0], 31'h1234});

        // R7: depth write mask
        for (int af = 0; af < 4; af++)
            for (int zm = 0; zm < 2; zm++)
                for (int ate = 0; ate < 2; ate++)
                    run("R7 depth mask", 1, mk_test(bit'(ate), 0, 0, af, 0, 0, 0, 0),
                        {31'h0, zm[0], 32'hFFFFFFFF}, 64'h0, 8'h0, 32'd0, 32'd0, 32'h0);

        // R8: frame write mask
        for (int mi = 0; mi < 6; mi++)
            for (int af = 0; af < 4; af++)
                for (int ate = 0; ate < 2; ate++)
                    run("R8 frame mask", 1, mk_test(bit'(ate), 0, 0, af, 0, 0, 0, 0),
                        64'h0, {masks[mi], 32'hFFFFFFFF}, 8'h0, 32'd0, 32'd0, 32'h0);

        // R9: valid then idle, enables return to zero
        run("R9 pass", 1, mk_test(0, 0, 0, 0, 0, 0, 0, 0), 64'h0, 64'h0, 8'h0, 32'd0, 32'd0, 32'h0);
        run("R9 drop", 0, mk_test(0, 0, 0, 0, 0, 0, 0, 0), 64'h0, 64'h0, 8'h0, 32'd0, 32'd0, 32'h0);

        finish_up();
    end
endmodule